// File: doc/BRIEF.md
# Depth-first tree search detector with a visit budget

This block finds the symbol vector closest to a received point for a small real-valued multi-antenna link. It takes an upper-triangular channel matrix and a received vector that has already been rotated into that triangular basis, both in signed fixed point. It then searches the tree of partial symbol vectors depth-first, from the top layer down to the leaf layer, and visits one node per clock cycle. At each layer the children are tried nearest first, that is, in order of their growing partial distance. Every leaf that improves on the best distance so far becomes the new best solution, and its distance becomes the new squared search radius. The search never returns to a node whose partial distance is not below that radius.

A node budget bounds the run time. Each cycle of a search visits exactly one node, and a step back up the tree may jump several layers in that single cycle. When the number of visited nodes reaches the budget, the search stops at once. It then reports the best leaf it has found and sets a flag that marks the result as possibly not optimal. If the tree runs out first, the flag is clear and the result is the exact minimum. A budget of zero means the search has no limit.

The control pins are plain. A single-cycle `start` is accepted only while the block is idle, and it captures the matrix, the vector and the budget. A single-cycle `done` marks the result. The result outputs then hold their values until the next accepted start. There is no back-pressure: the consumer must take the result when `done` is high, or read it later from the held outputs.

Top module: `sd_tree_search`

## Requirements
- R1: After reset, `busy`, `done` and `early_term` are 0 and `best_dist` is all ones.
- R2: A `start` seen while `busy` is 0 captures `r_flat`, `y_flat` and `budget` and sets `busy` on the next edge. A `start` seen while `busy` is 1 has no effect on the running search or on its result.
- R3: Layer N-1 is the top of the tree and layer 0 is the leaf layer. Field k of `best_idx` (bits k*SW +: SW) holds the index a of the symbol at layer k, whose level is 2a-(M-1). Row i of the matrix is packed as entries j = i..N-1 at entry offset i*N - i*(i-1)/2 + (j-i), each W bits wide, and `y_flat` holds entry k at bits k*W +: W. Children are tried in ascending partial distance, with ties going to the lower index. So with budget N, the first leaf is the layer-by-layer nearest-level choice, and it is returned with `early_term` 1.
- R4: With `budget` 0 the search runs until the tree is exhausted. It then reports `early_term` 0, and `best_dist` equals the minimum distance over all M^N vectors. The distance of the vector in `best_idx` equals `best_dist`.
- R5: With a nonzero budget B, a search that makes its B-th visit stops on that edge. `done` is then high B edges after the start edge, `early_term` is 1, and the best leaf found so far is reported.
- R6: If the tree is exhausted after V visits with V < B, `done` is high V+1 edges after the start edge, `early_term` is 0, and the result equals the unlimited result.
- R7: `done` is high for exactly one cycle, and only while `busy` is 0. The result outputs keep their values until the next accepted start.
- R8: A budget below N ends the search before any leaf is reached. The outputs are then `best_dist` all ones, `best_idx` zero and `early_term` 1.
- R9: Partial distances saturate at the all-ones value of DW bits. A saturated distance is never accepted as a leaf, and results are exact whenever the true minimum is below the all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search; ignored while busy |
| r_flat | input | W*N*(N+1)/2 | Upper-triangular matrix, signed entries |
| y_flat | input | N*W | Rotated received vector, signed entries |
| budget | input | CW | Maximum visited nodes, 0 = unlimited |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion strobe |
| early_term | output | 1 | Search stopped by the budget |
| best_idx | output | N*SW | Symbol indices of the best leaf |
| best_dist | output | DW | Squared distance of the best leaf |

## Verification
The hardest case to reach is a budget that runs out on exactly the last node the search would have visited anyway. Here the flag must still read as an early stop. One visit more must instead read as a clean exhaustion with the optimal answer. The bench first runs each random problem without a limit and measures its visit count from the cycle at which `done` rises. It then replays the same problem with the budget set to that count and to that count plus one. Directed vectors add the greedy first leaf, a budget too small to reach any leaf, a saturating input, and a start pulse during a search.

// File: rtl/sd_pkg.sv
package sd_pkg;

  // Signed amplitude of alphabet index idx for an m-ary real alphabet.
  function automatic int sd_level(input int idx, input int m);
    return 2 * idx - (m - 1);
  endfunction

  // Index width for a count of n items (at least one bit).
  function automatic int sd_idxw(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Entry position of (row i, column j >= i) in the packed upper triangle.
  function automatic int sd_tri(input int i, input int j, input int n);
    return i * n - (i * (i - 1)) / 2 + (j - i);
  endfunction

endpackage

// File: rtl/sd_interference.sv
// Computes, for every layer k, the received value with the contribution
// of the symbols already fixed on the current path (layers above k) removed.
module sd_interference #(
  parameter int N  = 4,
  parameter int M  = 4,
  parameter int W  = 8,
  parameter int BW = 15,
  parameter int SW = 2,
  parameter int NT = 10
) (
  input  logic [NT*W-1:0] r_tri,
  input  logic [N*W-1:0]  y_vec,
  input  logic [N*SW-1:0] path,
  output logic [N*BW-1:0] b_flat
);

  always_comb begin
    for (int k = 0; k < N; k++) begin
      logic signed [BW-1:0] acc;
      acc = BW'($signed(y_vec[k*W +: W]));
      for (int j = k + 1; j < N; j++) begin
        acc = acc - BW'($signed(r_tri[sd_pkg::sd_tri(k, j, N)*W +: W]))
                  * BW'(sd_pkg::sd_level(int'(path[j*SW +: SW]), M));
      end
      b_flat[k*BW +: BW] = acc;
    end
  end

endmodule

// File: rtl/sd_branch.sv
// One layer of the tree: evaluates every child of the node on the current
// path and picks the nearest unvisited one, then tests it against the radius.
module sd_branch #(
  parameter int M  = 4,
  parameter int W  = 8,
  parameter int BW = 15,
  parameter int DW = 24,
  parameter int SW = 2
) (
  input  logic signed [BW-1:0] b,
  input  logic signed [W-1:0]  rkk,
  input  logic [DW-1:0]        parent,
  input  logic [DW-1:0]        radius,
  input  logic [M-1:0]         seen,
  output logic                 live,
  output logic [SW-1:0]        pick,
  output logic [DW-1:0]        ped
);

  localparam int EW   = BW + 1;
  localparam int QW   = 2 * EW;
  localparam int SUMW = ((QW > DW) ? QW : DW) + 1;
  localparam logic [DW-1:0] DTOP = '1;

  logic [M*DW-1:0] cand_flat;

  for (genvar a = 0; a < M; a++) begin : g_child
    localparam int LV = sd_pkg::sd_level(a, M);
    logic signed [EW-1:0] err;
    logic signed [QW-1:0] ext;
    logic signed [QW-1:0] sq;
    logic [SUMW-1:0]      tot;
    assign err = EW'(b) - EW'(rkk) * EW'(LV);
    assign ext = QW'(err);
    assign sq  = ext * ext;
    assign tot = SUMW'(unsigned'(sq)) + SUMW'(parent);
    assign cand_flat[a*DW +: DW] = (tot >= SUMW'(DTOP)) ? DTOP : tot[DW-1:0];
  end

  always_comb begin
    logic          found;
    logic [DW-1:0] best;
    found = 1'b0;
    best  = DTOP;
    pick  = '0;
    for (int a = 0; a < M; a++) begin
      if (!seen[a] && (!found || cand_flat[a*DW +: DW] < best)) begin
        found = 1'b1;
        best  = cand_flat[a*DW +: DW];
        pick  = SW'(a);
      end
    end
    live = found && (best < radius);
    ped  = best;
  end

endmodule

// File: rtl/sd_pick.sv
// Chooses the lowest layer at or above the current depth that still holds
// a child inside the radius; that layer is where the next visit happens.
module sd_pick #(
  parameter int N   = 4,
  parameter int LIW = 2
) (
  input  logic [N-1:0]   live,
  input  logic [LIW-1:0] depth,
  output logic           any,
  output logic [LIW-1:0] sel
);

  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (live[k] && (k >= int'(depth))) begin
        any = 1'b1;
        sel = LIW'(k);
      end
    end
  end

endmodule

// File: rtl/sd_tree_search.sv
module sd_tree_search #(
  parameter int N  = 4,
  parameter int M  = 4,
  parameter int W  = 8,
  parameter int DW = 24,
  parameter int CW = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  start,
  input  logic [W*N*(N+1)/2-1:0]                r_flat,
  input  logic [N*W-1:0]                        y_flat,
  input  logic [CW-1:0]                         budget,
  output logic                                  busy,
  output logic                                  done,
  output logic                                  early_term,
  output logic [N*sd_pkg::sd_idxw(M)-1:0]       best_idx,
  output logic [DW-1:0]                         best_dist
);

  localparam int SW  = sd_pkg::sd_idxw(M);
  localparam int LIW = sd_pkg::sd_idxw(N);
  localparam int NT  = N * (N + 1) / 2;
  localparam int BW  = W + SW + $clog2(N) + 3;
  localparam logic [DW-1:0] DTOP = '1;

  // captured problem
  logic [NT*W-1:0]  r_q;
  logic [N*W-1:0]   y_q;
  logic [CW-1:0]    budget_q;

  // search state
  logic             busy_q, done_q, term_q;
  logic [LIW-1:0]   cur_q;
  logic [CW-1:0]    count_q;
  logic [DW-1:0]    radius_q;
  logic [SW-1:0]    sym_q  [N];
  logic [DW-1:0]    ped_q  [N];
  logic [M-1:0]     seen_q [N];
  logic [N*SW-1:0]  best_idx_q;
  logic [DW-1:0]    best_dist_q;

  // per-layer datapath
  logic [N*SW-1:0]  path_flat;
  logic [N*BW-1:0]  b_flat;
  logic [N-1:0]     live;
  logic [N*SW-1:0]  pick_flat;
  logic [N*DW-1:0]  pedc_flat;
  logic             any_live;
  logic [LIW-1:0]   tgt;
  logic [N*SW-1:0]  leaf_vec;

  for (genvar k = 0; k < N; k++) begin : g_path
    assign path_flat[k*SW +: SW] = sym_q[k];
    assign leaf_vec[k*SW +: SW]  = (k == 0) ? pick_flat[k*SW +: SW] : sym_q[k];
  end

  sd_interference #(
    .N(N), .M(M), .W(W), .BW(BW), .SW(SW), .NT(NT)
  ) u_intf (
    .r_tri  (r_q),
    .y_vec  (y_q),
    .path   (path_flat),
    .b_flat (b_flat)
  );

  for (genvar k = 0; k < N; k++) begin : g_layer
    logic [DW-1:0] parent;
    if (k == N - 1) begin : g_root
      assign parent = '0;
    end else begin : g_inner
      assign parent = ped_q[k+1];
    end

    sd_branch #(
      .M(M), .W(W), .BW(BW), .DW(DW), .SW(SW)
    ) u_branch (
      .b      ($signed(b_flat[k*BW +: BW])),
      .rkk    ($signed(r_q[sd_pkg::sd_tri(k, k, N)*W +: W])),
      .parent (parent),
      .radius (radius_q),
      .seen   (seen_q[k]),
      .live   (live[k]),
      .pick   (pick_flat[k*SW +: SW]),
      .ped    (pedc_flat[k*DW +: DW])
    );
  end

  sd_pick #(.N(N), .LIW(LIW)) u_pick (
    .live  (live),
    .depth (cur_q),
    .any   (any_live),
    .sel   (tgt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_q         <= '0;
      y_q         <= '0;
      budget_q    <= '0;
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      term_q      <= 1'b0;
      cur_q       <= '0;
      count_q     <= '0;
      radius_q    <= DTOP;
      best_idx_q  <= '0;
      best_dist_q <= DTOP;
      for (int k = 0; k < N; k++) begin
        sym_q[k]  <= '0;
        ped_q[k]  <= '0;
        seen_q[k] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          r_q         <= r_flat;
          y_q         <= y_flat;
          budget_q    <= budget;
          busy_q      <= 1'b1;
          term_q      <= 1'b0;
          cur_q       <= LIW'(N - 1);
          count_q     <= '0;
          radius_q    <= DTOP;
          best_idx_q  <= '0;
          best_dist_q <= DTOP;
          for (int k = 0; k < N; k++) seen_q[k] <= '0;
        end
      end else if (!any_live) begin
        // nothing left inside the radius: tree exhausted
        busy_q <= 1'b0;
        done_q <= 1'b1;
        term_q <= 1'b0;
      end else begin
        for (int k = 0; k < N; k++) begin
          if (int'(tgt) == k) begin
            sym_q[k]  <= pick_flat[k*SW +: SW];
            seen_q[k] <= seen_q[k] | (M'(1) << pick_flat[k*SW +: SW]);
            ped_q[k]  <= pedc_flat[k*DW +: DW];
          end
        end
        if (tgt == '0) begin
          radius_q    <= pedc_flat[DW-1:0];
          best_dist_q <= pedc_flat[DW-1:0];
          best_idx_q  <= leaf_vec;
        end else begin
          cur_q <= tgt - LIW'(1);
          for (int k = 0; k < N; k++) begin
            if (int'(tgt) == k + 1) seen_q[k] <= '0;
          end
        end
        count_q <= count_q + CW'(1);
        if ((budget_q != '0) && ((count_q + CW'(1)) == budget_q)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          term_q <= 1'b1;
        end
      end
    end
  end

  assign busy       = busy_q;
  assign done       = done_q;
  assign early_term = term_q;
  assign best_idx   = best_idx_q;
  assign best_dist  = best_dist_q;

endmodule

// File: rtl/sd_tree_search_chk.sv
module sd_tree_search_chk #(
  parameter int DW = 24,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [CW-1:0] budget,
  input logic          busy,
  input logic          done,
  input logic          early_term,
  input logic [DW-1:0] best_dist
);

  // independent count of busy cycles and the budget of the running search
  logic [CW-1:0] cyc;
  logic [CW-1:0] bud_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc   <= '0;
      bud_l <= '0;
    end else if (start && !busy) begin
      cyc   <= '0;
      bud_l <= budget;
    end else if (busy) begin
      cyc <= cyc + CW'(1);
    end
  end

  assert_start_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_budget_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && early_term) |-> (cyc == bud_l));

  assert_exhaust_in_budget_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !early_term) |-> ((bud_l == '0) || (cyc <= bud_l)));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_result_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(best_dist));

  assert_radius_shrinks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (best_dist <= $past(best_dist)));

endmodule

bind sd_tree_search sd_tree_search_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .budget     (budget),
  .busy       (busy),
  .done       (done),
  .early_term (early_term),
  .best_dist  (best_dist)
);

// File: tb/sim_sd_tree_search.sv
module sim_sd_tree_search;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int M  = 4;
  localparam int W  = 8;
  localparam int DW = 16;
  localparam int CW = 16;
  localparam int SW = 2;
  localparam int NT = N * (N + 1) / 2;
  localparam int DTOP = (1 << DW) - 1;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic              rst_n;
  logic              start;
  logic [NT*W-1:0]   r_flat;
  logic [N*W-1:0]    y_flat;
  logic [CW-1:0]     budget;
  logic              busy, done, early_term;
  logic [N*SW-1:0]   best_idx;
  logic [DW-1:0]     best_dist;

  sd_tree_search #(.N(N), .M(M), .W(W), .DW(DW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .r_flat(r_flat), .y_flat(y_flat),
    .budget(budget), .busy(busy), .done(done), .early_term(early_term),
    .best_idx(best_idx), .best_dist(best_dist)
  );

  int checks = 0;
  int errors = 0;
  int Rm [N][N];
  int Yv [N];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int lvl(input logic [SW-1:0] i);
    return 2 * int'(i) - (M - 1);
  endfunction

  function automatic int sat(input int v);
    return (v > DTOP) ? DTOP : v;
  endfunction

  function automatic int dist_of(input logic [N*SW-1:0] v);
    int ped;
    ped = 0;
    for (int k = N - 1; k >= 0; k--) begin
      int b, e;
      b = Yv[k];
      for (int j = k + 1; j < N; j++) b -= Rm[k][j] * lvl(v[j*SW +: SW]);
      e = b - Rm[k][k] * lvl(v[k*SW +: SW]);
      ped = sat(ped + e * e);
    end
    return ped;
  endfunction

  function automatic int exh_min();
    int best;
    best = DTOP;
    for (int c = 0; c < M ** N; c++) begin
      int d;
      d = dist_of((N*SW)'(c));
      if (d < best) best = d;
    end
    return best;
  endfunction

  function automatic logic [N*SW-1:0] nc_vec();
    logic [N*SW-1:0] v;
    v = '0;
    for (int k = N - 1; k >= 0; k--) begin
      int b, bestq, bi;
      b = Yv[k];
      for (int j = k + 1; j < N; j++) b -= Rm[k][j] * lvl(v[j*SW +: SW]);
      bestq = -1;
      bi = 0;
      for (int a = 0; a < M; a++) begin
        int e;
        e = b - Rm[k][k] * (2 * a - (M - 1));
        if (bestq < 0 || e * e < bestq) begin
          bestq = e * e;
          bi = a;
        end
      end
      v[k*SW +: SW] = SW'(bi);
    end
    return v;
  endfunction

  task automatic load();
    for (int i = 0; i < N; i++) begin
      for (int j = i; j < N; j++)
        r_flat[(i * N - (i * (i - 1)) / 2 + (j - i)) * W +: W] = W'(Rm[i][j]);
      y_flat[i*W +: W] = W'(Yv[i]);
    end
  endtask

  task automatic rand_prob();
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) Rm[i][j] = 0;
      Rm[i][i] = int'($urandom_range(1, 8));
      for (int j = i + 1; j < N; j++) Rm[i][j] = int'($urandom_range(0, 8)) - 4;
      Yv[i] = int'($urandom_range(0, 40)) - 20;
    end
  endtask

  // e = edges after the start edge at which done is first observed
  task automatic run(input int bud, output int e);
    @(negedge clk);
    load();
    budget = CW'(bud);
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    e = 0;
    while (!done && e < 4000) begin
      @(negedge clk);
      e++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog R5 actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int e, e2, ex, v;
    logic [N*SW-1:0] nv;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0; budget = '0; r_flat = '0; y_flat = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1", "busy", busy, 0);
    chk(done == 1'b0 && early_term == 1'b0, "R1", "done/flag", {done, early_term}, 0);
    chk(best_dist == DW'(DTOP), "R1", "best_dist", best_dist, DTOP);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: budget N yields the greedy first leaf
    for (int t = 0; t < 6; t++) begin
      rand_prob();
      if (t == 0) begin
        for (int i = 0; i < N; i++) begin
          for (int j = 0; j < N; j++) Rm[i][j] = (i == j) ? 1 : 0;
          Yv[i] = 2 * i - 3;
        end
      end
      nv = nc_vec();
      run(N, e);
      chk(best_idx == nv, "R3", "greedy vector", best_idx, nv);
      chk(best_dist == DW'(dist_of(nv)), "R3", "greedy dist", best_dist, dist_of(nv));
      chk(early_term == 1'b1 && e == N, "R3", "flag/edges", e, N);
    end

    // R4/R5/R6: unlimited search, then budgets at and past its visit count
    for (int t = 0; t < 40; t++) begin
      rand_prob();
      ex = exh_min();
      run(0, e);
      chk(early_term == 1'b0, "R4", "flag unlimited", early_term, 0);
      chk(best_dist == DW'(ex), "R4", "min distance", best_dist, ex);
      chk(dist_of(best_idx) == int'(best_dist), "R4", "vector distance",
          dist_of(best_idx), best_dist);
      v = e - 1;
      run(v, e2);
      chk(early_term == 1'b1 && e2 == v, "R5", "stop at budget", e2, v);
      chk(int'(best_dist) >= ex, "R5", "partial not below min", best_dist, ex);
      run(v + 1, e2);
      chk(early_term == 1'b0 && e2 == v + 1, "R6", "exhaust before budget", e2, v + 1);
      chk(best_dist == DW'(ex), "R6", "same as unlimited", best_dist, ex);
    end

    // R8: budget below N reaches no leaf
    rand_prob();
    run(2, e);
    chk(best_dist == DW'(DTOP) && best_idx == '0, "R8", "no leaf", best_dist, DTOP);
    chk(early_term == 1'b1 && e == 2, "R8", "flag/edges", e, 2);

    // R9: saturating partial distances
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) Rm[i][j] = (i == j) ? 1 : 0;
      Yv[i] = -128;
    end
    run(0, e);
    chk(best_dist == DW'(62500), "R9", "saturated search min", best_dist, 62500);
    chk(best_dist == DW'(exh_min()), "R9", "matches saturated ref", best_dist, exh_min());

    // R2: start during a search is ignored; R7 strobe and hold
    rand_prob();
    ex = exh_min();
    @(negedge clk);
    load();
    budget = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    y_flat = '1;
    budget = CW'(1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    e = 0;
    while (!done && e < 4000) begin
      @(negedge clk);
      e++;
    end
    chk(best_dist == DW'(ex) && early_term == 1'b0, "R2", "ignored start", best_dist, ex);
    nv = best_idx;
    v = int'(best_dist);
    @(negedge clk);
    chk(done == 1'b0, "R7", "done one cycle", done, 0);
    repeat (3) @(negedge clk);
    chk(best_dist == DW'(v) && best_idx == nv, "R7", "result held", best_dist, v);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule